// File: doc/BRIEF.md
# Memory Array Summing Engine

This block is a fixed-function engine that adds up an array of signed or unsigned 32-bit words stored in memory, starting at address zero. It stays idle after reset and issues no memory traffic until a start strobe arrives. On that strobe it latches an element count. It then fetches one word per cycle through a read port whose data comes back in the same cycle. Addresses are byte addresses that advance by four on each fetch.

When the last word has been added, the engine shows the total on its result output and raises a valid flag. It then stays in that finished state, ignoring every input, until it is reset. The engine runs one job per reset. The total wraps modulo 2^32.

Internally, a structural datapath holds the captured count, the element counter, the address register, the running sum, an adder and an end-of-array comparator. A controller drives it, built as a state register, one next-state block and one output block.

Top module: `arr_accum`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, `mem_rd_en` and `sum_valid` are 0 and `sum_out` is 0.
- R2: Before a cycle with `start` high is seen, `mem_rd_en` stays 0 and `sum_valid` stays 0, whatever `elem_count` holds.
- R3: The `elem_count` value present in the `start` cycle sets the number of reads N. Starting in the cycle after `start`, `mem_rd_en` is high for exactly N consecutive cycles. In cycle i (counting from 0), `mem_rd_addr` equals 4*i.
- R4: `sum_out` in the finished state equals the sum of the N words returned on `mem_rd_data` during the read cycles, taken modulo 2^32. An all-ones word therefore wraps the total.
- R5: `sum_valid` rises in the cycle right after the last read and then stays high, with `sum_out` unchanged, until reset.
- R6: A count of 0 captured at `start` makes `sum_valid` high in the next cycle with `sum_out` equal to 0, and no read is issued.
- R7: Once the engine has started, changes on `start` and `elem_count` have no effect on the addresses issued, on the number of reads, or on the total.
- R8: `mem_rd_en` and `sum_valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, sampled while idle |
| elem_count | input | 14 | Number of 32-bit elements to sum |
| sum_valid | output | 1 | High once the total is ready |
| sum_out | output | 32 | Accumulated total |
| mem_rd_en | output | 1 | Read request valid |
| mem_rd_addr | output | 16 | Byte address of the requested word |
| mem_rd_data | input | 32 | Read data, returned in the same cycle |

## Verification
The bench sweeps the element count over 0, 1, small odd and even values, and the maximum of 16383. It uses three memory fill patterns: an address hash, the element index, and all-ones words that force the total to wrap. Each pattern is aimed at a specific fault. An off-by-one end comparator would show up as one read too many or too few and a shifted valid cycle. A wrong stride or a missing address clear would give a wrong address sequence. A narrow or saturating adder would fail the all-ones case. A zero count that fell through into the fetch state would issue a stray read. Throughout a run, and after it finishes, the bench toggles `start` and scrambles `elem_count`. An engine that re-sampled those inputs would change its read count or restart, and the bench would see it.

// File: rtl/arr_accum_pkg.sv
package arr_accum_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_DONE  = 2'd2
   } acc_state_t;

   localparam int unsigned STATE_W = 2;

endpackage

// File: rtl/accum_reg.sv
module accum_reg #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   initial begin
      assert (WIDTH > 0) else $error("accum_reg: WIDTH must be positive");
   end

   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else if (en)
         q <= d;
   end

endmodule

// File: rtl/accum_dpath.sv
module accum_dpath #(
   parameter int unsigned CNT_W        = 14,
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned STRIDE_BYTES = 4,
   parameter bit          USE_ADDR_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CNT_W-1:0]  size_in,
   input  logic              size_en,
   input  logic              fetch_en,
   input  logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] sum,
   output logic              size_zero,
   output logic              last
);

   localparam int unsigned STRIDE_SH = $clog2(STRIDE_BYTES);
   localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(STRIDE_BYTES);

   initial begin
      assert (STRIDE_BYTES > 0 && (1 << STRIDE_SH) == STRIDE_BYTES)
         else $error("accum_dpath: STRIDE_BYTES must be a power of two");
      assert (ADDR_W >= CNT_W + STRIDE_SH)
         else $error("accum_dpath: ADDR_W too narrow for CNT_W elements");
   end

   logic [CNT_W-1:0]  size_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  cnt_inc;
   logic [DATA_W-1:0] sum_q;
   logic [DATA_W-1:0] sum_d;

   // captured element count
   accum_reg #(.WIDTH(CNT_W)) u_size_reg (
      .clk (clk), .rst (rst), .en (size_en), .d (size_in), .q (size_q)
   );

   // element counter
   assign cnt_inc = cnt_q + CNT_W'(1);
   accum_reg #(.WIDTH(CNT_W)) u_cnt_reg (
      .clk (clk), .rst (rst), .en (fetch_en), .d (cnt_inc), .q (cnt_q)
   );

   // running sum and its adder
   assign sum_d = sum_q + rdata;
   accum_reg #(.WIDTH(DATA_W)) u_sum_reg (
      .clk (clk), .rst (rst), .en (fetch_en), .d (sum_d), .q (sum_q)
   );

   // address source: dedicated register or derived from counter
   generate
      if (USE_ADDR_REG) begin : g_addr_reg
         logic [ADDR_W-1:0] addr_q;
         logic [ADDR_W-1:0] addr_d;
         assign addr_d = addr_q + ADDR_STEP;
         accum_reg #(.WIDTH(ADDR_W)) u_addr_reg (
            .clk (clk), .rst (rst), .en (fetch_en), .d (addr_d), .q (addr_q)
         );
         assign addr = addr_q;
      end else begin : g_addr_shift
         assign addr = ADDR_W'(cnt_q) << STRIDE_SH;
      end
   endgenerate

   // comparators
   assign size_zero = (size_in == '0);
   assign last      = (cnt_inc == size_q);
   assign sum       = sum_q;

   AST_SUM_ACCUMULATES: assert property (@(posedge clk) disable iff (rst)
      fetch_en |=> sum_q == $past(sum_q) + $past(rdata)); // R4

   AST_SUM_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !fetch_en |=> $stable(sum_q)); // R5

endmodule

// File: rtl/accum_ctrl.sv
module accum_ctrl
   import arr_accum_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic go,
   input  logic size_zero,
   input  logic last,
   output logic size_en,
   output logic fetch_en,
   output logic req_val,
   output logic res_val
);

   logic [STATE_W-1:0] state_q;
   logic [STATE_W-1:0] state_d;
   acc_state_t         state;
   acc_state_t         state_nx;

   // state register
   accum_reg #(.WIDTH(STATE_W)) u_state_reg (
      .clk (clk), .rst (rst), .en (1'b1), .d (state_d), .q (state_q)
   );
   assign state   = acc_state_t'(state_q);
   assign state_d = state_nx;

   // next-state logic
   always_comb begin
      state_nx = state;
      case (state)
         ST_IDLE:  if (go) state_nx = size_zero ? ST_DONE : ST_FETCH;
         ST_FETCH: if (last) state_nx = ST_DONE;
         ST_DONE:  state_nx = ST_DONE;
         default:  state_nx = ST_IDLE;
      endcase
   end

   // output logic
   always_comb begin
      size_en  = 1'b0;
      fetch_en = 1'b0;
      req_val  = 1'b0;
      res_val  = 1'b0;
      case (state)
         ST_IDLE:  size_en = go;
         ST_FETCH: begin
            fetch_en = 1'b1;
            req_val  = 1'b1;
         end
         ST_DONE:  res_val = 1'b1;
         default:  ;
      endcase
   end

   AST_DONE_ABSORBS: assert property (@(posedge clk) disable iff (rst)
      state == ST_DONE |=> state == ST_DONE); // R5

   AST_NO_START_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
      state == ST_IDLE && !go |=> state == ST_IDLE); // R2

endmodule

// File: rtl/arr_accum.sv
module arr_accum #(
   parameter int unsigned CNT_W        = 14,
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned STRIDE_BYTES = 4,
   parameter bit          USE_ADDR_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [CNT_W-1:0]  elem_count,
   output logic              sum_valid,
   output logic [DATA_W-1:0] sum_out,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic [DATA_W-1:0] mem_rd_data
);

   localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(STRIDE_BYTES);

   logic size_en;
   logic fetch_en;
   logic size_zero;
   logic last;

   accum_ctrl u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .go        (start),
      .size_zero (size_zero),
      .last      (last),
      .size_en   (size_en),
      .fetch_en  (fetch_en),
      .req_val   (mem_rd_en),
      .res_val   (sum_valid)
   );

   accum_dpath #(
      .CNT_W        (CNT_W),
      .ADDR_W       (ADDR_W),
      .DATA_W       (DATA_W),
      .STRIDE_BYTES (STRIDE_BYTES),
      .USE_ADDR_REG (USE_ADDR_REG)
   ) u_dpath (
      .clk       (clk),
      .rst       (rst),
      .size_in   (elem_count),
      .size_en   (size_en),
      .fetch_en  (fetch_en),
      .rdata     (mem_rd_data),
      .addr      (mem_rd_addr),
      .sum       (sum_out),
      .size_zero (size_zero),
      .last      (last)
   );

   AST_EXCLUSIVE_OUT: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd_en && sum_valid)); // R8

   AST_FIRST_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
      $rose(mem_rd_en) |-> mem_rd_addr == '0); // R3

   AST_ADDR_STRIDE: assert property (@(posedge clk) disable iff (rst)
      mem_rd_en && $past(mem_rd_en) |-> mem_rd_addr == $past(mem_rd_addr) + ADDR_STEP); // R3

   AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
      sum_valid |=> sum_valid && $stable(sum_out)); // R5

   AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst)
      start && !mem_rd_en && !sum_valid && elem_count == '0 |=> sum_valid && sum_out == '0); // R6

endmodule

// File: tb/arr_accum_tb_top.sv
module arr_accum_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [13:0] elem_count = '0;
   logic        sum_valid;
   logic [31:0] sum_out;
   logic        mem_rd_en;
   logic [15:0] mem_rd_addr;
   logic [31:0] mem_rd_data;

   int checks = 0;
   int fails  = 0;
   int mode   = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   function automatic logic [31:0] word_at(int idx, int m);
      case (m)
         1:       return 32'hFFFF_FFFF;
         2:       return 32'(idx);
         default: return (32'(idx) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
      endcase
   endfunction

   assign mem_rd_data = word_at(int'(mem_rd_addr >> 2), mode);

   arr_accum dut_i (
      .clk         (clk),
      .rst         (rst),
      .start       (start),
      .elem_count  (elem_count),
      .sum_valid   (sum_valid),
      .sum_out     (sum_out),
      .mem_rd_en   (mem_rd_en),
      .mem_rd_addr (mem_rd_addr),
      .mem_rd_data (mem_rd_data)
   );

   task automatic check(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] expect_sum(int n, int m);
      logic [31:0] s = '0;
      if (m == 1) return 32'(-n);
      if (m == 2) return 32'((longint'(n) * (n - 1)) / 2);
      for (int i = 0; i < n; i++) s += word_at(i, m);
      return s;
   endfunction

   task automatic run_case(int n, int m);
      int addr_bad = 0;
      int en_bad   = 0;
      int first_bad_addr = 0;
      logic [31:0] exp_sum;
      mode = m;
      exp_sum = expect_sum(n, m);
      rst = 1'b1;
      start = 1'b0;
      elem_count = 14'h3FFF;
      repeat (2) @(negedge clk);
      check(!mem_rd_en && !sum_valid && sum_out == 0, "R1", "state under reset",
            {mem_rd_en, sum_valid, sum_out}, 0);
      rst = 1'b0;
      @(negedge clk);
      check(!mem_rd_en && !sum_valid && sum_out == 0, "R1", "state after reset",
            {mem_rd_en, sum_valid, sum_out}, 0);
      // idle with no start: nothing moves
      for (int k = 0; k < 4; k++) begin
         elem_count = 14'(k * 77 + 3);
         @(negedge clk);
         if (mem_rd_en || sum_valid) en_bad++;
      end
      check(en_bad == 0, "R2", "activity before start", en_bad, 0);
      en_bad = 0;
      elem_count = 14'(n);
      start = 1'b1;
      @(negedge clk);
      // R7: scramble inputs once started
      start = 1'b0;
      elem_count = ~14'(n);
      for (int i = 0; i < n; i++) begin
         if (!mem_rd_en) en_bad++;
         if (mem_rd_addr != 16'(4 * i)) begin
            if (addr_bad == 0) first_bad_addr = i;
            addr_bad++;
         end
         start = i[0];
         elem_count = 14'(i * 13);
         @(negedge clk);
      end
      check(en_bad == 0, "R3", $sformatf("n=%0d read enable gaps", n), en_bad, 0);
      check(addr_bad == 0, "R3", $sformatf("n=%0d address at index %0d", n, first_bad_addr),
            addr_bad, 0);
      check(!mem_rd_en, "R3", $sformatf("n=%0d read count", n), mem_rd_en, 0);
      check(sum_valid, "R5", $sformatf("n=%0d valid after last read", n), sum_valid, 1);
      if (n == 0)
         check(sum_out == 0, "R6", "zero-count total", sum_out, 0);
      else
         check(sum_out == exp_sum, "R4", $sformatf("n=%0d mode=%0d total", n, m),
               sum_out, exp_sum);
      // finished state is sticky and ignores inputs
      en_bad = 0;
      for (int k = 0; k < 6; k++) begin
         start = k[0];
         elem_count = 14'(k * 911 + 5);
         @(negedge clk);
         if (mem_rd_en || !sum_valid || sum_out != exp_sum) en_bad++;
      end
      check(en_bad == 0, "R7", $sformatf("n=%0d inputs ignored when done", n), en_bad, 0);
      start = 1'b0;
   endtask

   initial begin
      while (cycles < 150000) begin
         @(posedge clk);
         cycles++;
         if (!rst && mem_rd_en && sum_valid) begin
            checks++;
            fails++;
            $display("FAIL R8 read and valid together actual=1 expected=0");
         end
      end
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      run_case(0, 0);
      run_case(1, 0);
      run_case(2, 2);
      run_case(3, 1);
      run_case(4, 0);
      run_case(5, 2);
      run_case(7, 1);
      run_case(16, 0);
      run_case(100, 2);
      run_case(16383, 0);
      run_case(1000, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule